// File: doc/BRIEF.md
# Converter Control Sequencer

This block sits behind a byte-level serial receive path and configures a small multi-channel data converter. The receive path reports start and stop conditions and delivers each received byte with a one-cycle valid strobe. The block sorts these events into the phases of a transfer. After each start it compares the first byte with the device identity, which is a fixed four-bit pattern followed by three strap pins. The last bit of that byte gives the transfer direction.

In a write transfer to this device, the next byte becomes the control byte. Its fields enable the analog output, select one of four input configurations, set auto-increment and pick an input channel. The block keeps the active channel number within the channels that the selected configuration offers. When auto-increment is set, it moves the channel forward on every conversion-done pulse. Any further bytes in the same write are passed on as output-converter data.

Top module: `conv_ctrl_seq`

## Requirements
- R1: After reset, the control register reads 0x00, the channel is 0, analog output enable and clock enable are low, the high-impedance flag is high, and the match flag and data strobe are low.
- R2: The first byte after a start matches when bits 7:4 equal 1001 and bits 3:1 equal the strap input. The match flag rises in the cycle after that byte, and the direction output takes bit 0 (1 means read).
- R3: A start clears the match flag. After a non-matching address byte, every byte is ignored until the next start.
- R4: In a matched write, the byte that follows the address is loaded into the control register in the cycle after it arrives, with bits 7 and 3 forced to zero.
- R5: Analog output enable equals control bit 6. The converter clock enable is high whenever bit 6 is high, and the high-impedance flag is its inverse.
- R6: The input-mode output equals control bits 5:4, and the auto-increment output equals control bit 2.
- R7: The active channel is the channel select in bits 1:0, limited to the highest channel of the mode. Mode 0 has channels 0 to 3, modes 1 and 2 have channels 0 to 2, and mode 3 has channels 0 to 1.
- R8: With auto-increment set, each conversion-done pulse moves the channel up by one, and from the highest channel of the mode it moves to 0. With auto-increment clear, the channel does not change.
- R9: Bytes after the control byte in the same write leave the control register unchanged. Each one produces a one-cycle data strobe, with that byte on the data output, in the cycle after it arrives.
- R10: A stop ends the transfer and clears the match flag without changing the control register. Bytes after a stop are ignored.
- R11: In a matched read transfer, the bytes that follow the address change neither the control register nor the data strobe.
- R12: When a control byte load and a conversion-done pulse fall in the same cycle, the channel takes the clamped select from the new control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start condition strobe |
| stop_i | input | 1 | Stop condition strobe |
| byte_vld_i | input | 1 | Received byte valid strobe |
| byte_i | input | 8 | Received byte |
| conv_done_i | input | 1 | Conversion finished pulse |
| strap_i | input | 3 | Programmable address straps |
| addr_match_o | output | 1 | Current transfer addresses this device |
| dir_rd_o | output | 1 | Direction of matched transfer, 1 = read |
| ctrl_o | output | 8 | Control register contents |
| in_mode_o | output | 2 | Input configuration |
| chan_o | output | 2 | Active input channel |
| auto_inc_o | output | 1 | Auto-increment enabled |
| aout_en_o | output | 1 | Analog output enable |
| osc_en_o | output | 1 | Converter clock enable |
| aout_hiz_o | output | 1 | Analog output high-impedance |
| dac_vld_o | output | 1 | Output-converter data strobe |
| dac_data_o | output | 8 | Output-converter data |

## Verification
The assertions assume that the receive path never raises a start, a stop and a byte strobe in the same cycle, that each strobe lasts a single cycle, and that the strap pins do not change during a transfer. The bench drives each event on its own falling edge and releases it on the next one. It keeps the straps at a fixed value. When it raises conversion-done together with a byte, it does so only in the collision test, which is permitted.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  localparam int BYTE_W   = 8;
  localparam int MODE_W   = 2;
  localparam int CH_W     = 2;
  localparam int BIT_AOUT = 6;
  localparam int MODE_LO  = 4;
  localparam int BIT_AUTO = 2;
  localparam int SEL_LO   = 0;
  localparam logic [BYTE_W-1:0] RSV_MASK = 8'b1000_1000;

  typedef enum logic [2:0] {PH_IDLE, PH_ADDR, PH_CTRL, PH_DATA, PH_SKIP} phase_t;

  // highest channel number the input mode offers
  function automatic logic [CH_W-1:0] top_chan(input logic [MODE_W-1:0] mode);
    case (mode)
      2'd0:    top_chan = 2'd3;
      2'd3:    top_chan = 2'd1;
      default: top_chan = 2'd2;
    endcase
  endfunction

  function automatic logic [CH_W-1:0] clamp_chan(input logic [CH_W-1:0] sel,
                                                  input logic [MODE_W-1:0] mode);
    clamp_chan = (sel > top_chan(mode)) ? top_chan(mode) : sel;
  endfunction

  function automatic logic [CH_W-1:0] next_chan(input logic [CH_W-1:0] cur,
                                                 input logic [MODE_W-1:0] mode);
    next_chan = (cur >= top_chan(mode)) ? '0 : cur + 1'b1;
  endfunction
endpackage

// File: rtl/xfer_phase.sv
module xfer_phase
  import conv_seq_pkg::*;
#(
  parameter logic [3:0] FIXED_ID = 4'b1001,
  parameter int         STRAP_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [STRAP_W-1:0] strap_i,
  output logic              addr_match_o,
  output logic              dir_rd_o,
  output logic              ctrl_load_o,
  output logic              dac_vld_o,
  output logic [BYTE_W-1:0] dac_data_o
);
  localparam int ID_W = BYTE_W - 1;

  phase_t            phase_q;
  logic              match_q, rd_q, dac_vld_q;
  logic [BYTE_W-1:0] dac_data_q;
  logic              byte_ev, id_hit, dac_ev;

  assign byte_ev     = byte_vld_i && !start_i && !stop_i;
  assign id_hit      = (byte_i[BYTE_W-1:1] == {FIXED_ID, strap_i});
  assign ctrl_load_o = byte_ev && (phase_q == PH_CTRL);
  assign dac_ev      = byte_ev && (phase_q == PH_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      match_q <= 1'b0;
      rd_q    <= 1'b0;
    end else if (start_i) begin
      phase_q <= PH_ADDR;
      match_q <= 1'b0;
      rd_q    <= 1'b0;
    end else if (stop_i) begin
      phase_q <= PH_IDLE;
      match_q <= 1'b0;
    end else if (byte_ev) begin
      case (phase_q)
        PH_ADDR: begin
          match_q <= id_hit;
          rd_q    <= id_hit && byte_i[0];
          phase_q <= (id_hit && !byte_i[0]) ? PH_CTRL : PH_SKIP;
        end
        PH_CTRL: phase_q <= PH_DATA;
        default: phase_q <= phase_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_vld_q  <= 1'b0;
      dac_data_q <= '0;
    end else begin
      dac_vld_q <= dac_ev;
      if (dac_ev) dac_data_q <= byte_i;
    end
  end

  assign addr_match_o = match_q;
  assign dir_rd_o     = rd_q;
  assign dac_vld_o    = dac_vld_q;
  assign dac_data_o   = dac_data_q;

  p_load_after_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_load_o |-> (match_q && !rd_q));
  p_start_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!match_q && phase_q == PH_ADDR));
  p_dac_in_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dac_vld_q |-> (match_q && !rd_q));
  p_stop_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !start_i) |=> !match_q);
endmodule

// File: rtl/ctrl_reg.sv
module ctrl_reg
  import conv_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [BYTE_W-1:0] ctrl_o
);
  logic [BYTE_W-1:0] ctrl_q, ctrl_d;

  // reserved positions are forced low as the byte is taken in
  for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
    if (RSV_MASK[i]) begin : g_rsv
      assign ctrl_d[i] = 1'b0;
    end else begin : g_use
      assign ctrl_d[i] = byte_i[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctrl_q <= '0;
    else if (load_i) ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;

  p_ctrl_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(ctrl_q));
endmodule

// File: rtl/chan_seq.sv
module chan_seq
  import conv_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [CH_W-1:0]   sel_i,
  input  logic [MODE_W-1:0] load_mode_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              auto_i,
  input  logic              conv_done_i,
  output logic [CH_W-1:0]   chan_o
);
  logic [CH_W-1:0] chan_q;
  logic            step;

  assign step = conv_done_i && auto_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      chan_q <= '0;
    else if (load_i) chan_q <= clamp_chan(sel_i, load_mode_i);
    else if (step)   chan_q <= next_chan(chan_q, mode_i);
  end

  assign chan_o = chan_q;

  p_chan_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    chan_q <= top_chan(mode_i));
  p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load_i && chan_q == top_chan(mode_i)) |=> (chan_q == '0));
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !step) |=> $stable(chan_q));
  p_load_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && conv_done_i) |=> (chan_q == clamp_chan($past(sel_i), $past(load_mode_i))));
endmodule

// File: rtl/conv_ctrl_seq.sv
module conv_ctrl_seq
  import conv_seq_pkg::*;
#(
  parameter logic [3:0] FIXED_ID = 4'b1001,
  parameter int         STRAP_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic               byte_vld_i,
  input  logic [7:0]         byte_i,
  input  logic               conv_done_i,
  input  logic [STRAP_W-1:0] strap_i,
  output logic               addr_match_o,
  output logic               dir_rd_o,
  output logic [7:0]         ctrl_o,
  output logic [1:0]         in_mode_o,
  output logic [1:0]         chan_o,
  output logic               auto_inc_o,
  output logic               aout_en_o,
  output logic               osc_en_o,
  output logic               aout_hiz_o,
  output logic               dac_vld_o,
  output logic [7:0]         dac_data_o
);
  logic              ctrl_load;
  logic [BYTE_W-1:0] ctrl_q;

  xfer_phase #(.FIXED_ID(FIXED_ID), .STRAP_W(STRAP_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .byte_vld_i(byte_vld_i), .byte_i(byte_i), .strap_i(strap_i),
    .addr_match_o(addr_match_o), .dir_rd_o(dir_rd_o),
    .ctrl_load_o(ctrl_load), .dac_vld_o(dac_vld_o), .dac_data_o(dac_data_o)
  );

  ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .load_i(ctrl_load), .byte_i(byte_i), .ctrl_o(ctrl_q)
  );

  chan_seq u_chan (
    .clk(clk), .rst_n(rst_n), .load_i(ctrl_load),
    .sel_i(byte_i[SEL_LO +: CH_W]), .load_mode_i(byte_i[MODE_LO +: MODE_W]),
    .mode_i(ctrl_q[MODE_LO +: MODE_W]), .auto_i(ctrl_q[BIT_AUTO]),
    .conv_done_i(conv_done_i), .chan_o(chan_o)
  );

  assign ctrl_o     = ctrl_q;
  assign in_mode_o  = ctrl_q[MODE_LO +: MODE_W];
  assign auto_inc_o = ctrl_q[BIT_AUTO];
  assign aout_en_o  = ctrl_q[BIT_AOUT];
  assign osc_en_o   = ctrl_q[BIT_AOUT];
  assign aout_hiz_o = !ctrl_q[BIT_AOUT];

  p_aout_from_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_load |=> (aout_en_o == $past(byte_i[BIT_AOUT])));
  p_osc_with_aout_r5: assert property (@(posedge clk) disable iff (!rst_n)
    aout_en_o |-> (osc_en_o && !aout_hiz_o));
endmodule

// File: tb/conv_ctrl_seq_bench.sv
`timescale 1ns/1ps
module conv_ctrl_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 0, stop_i = 0, byte_vld_i = 0, conv_done_i = 0;
  logic [7:0] byte_i = '0;
  logic [2:0] strap_i = 3'b101;
  logic addr_match_o, dir_rd_o, auto_inc_o, aout_en_o, osc_en_o, aout_hiz_o, dac_vld_o;
  logic [7:0] ctrl_o, dac_data_o;
  logic [1:0] in_mode_o, chan_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [7:0] A_WR = 8'h9A;  // 1001 101 0
  localparam logic [7:0] A_RD = 8'h9B;

  always #4 clk = ~clk;

  conv_ctrl_seq u_conv_ctrl_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .byte_vld_i(byte_vld_i), .byte_i(byte_i), .conv_done_i(conv_done_i),
    .strap_i(strap_i), .addr_match_o(addr_match_o), .dir_rd_o(dir_rd_o),
    .ctrl_o(ctrl_o), .in_mode_o(in_mode_o), .chan_o(chan_o),
    .auto_inc_o(auto_inc_o), .aout_en_o(aout_en_o), .osc_en_o(osc_en_o),
    .aout_hiz_o(aout_hiz_o), .dac_vld_o(dac_vld_o), .dac_data_o(dac_data_o)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  // expected channel, computed from the channel count of each mode
  function automatic int exp_top(input int mode);
    int n;
    n = (mode == 0) ? 4 : ((mode == 3) ? 2 : 3);
    return n - 1;
  endfunction

  task automatic pulse_start();
    @(negedge clk) start_i = 1;
    @(negedge clk) start_i = 0;
  endtask
  task automatic pulse_stop();
    @(negedge clk) stop_i = 1;
    @(negedge clk) stop_i = 0;
  endtask
  task automatic send(input logic [7:0] b);
    @(negedge clk) begin byte_vld_i = 1; byte_i = b; end
    @(negedge clk) byte_vld_i = 0;
  endtask
  task automatic conv();
    @(negedge clk) conv_done_i = 1;
    @(negedge clk) conv_done_i = 0;
  endtask
  task automatic write_ctrl(input logic [7:0] c);
    pulse_start(); send(A_WR); send(c); pulse_stop();
  endtask

  task automatic t_reset();
    check("R1 ctrl", ctrl_o, 0);
    check("R1 chan", chan_o, 0);
    check("R1 aout", aout_en_o, 0);
    check("R1 osc", osc_en_o, 0);
    check("R1 hiz", aout_hiz_o, 1);
    check("R1 match", addr_match_o, 0);
    check("R1 dac", dac_vld_o, 0);
  endtask

  task automatic t_write_all_ones();
    pulse_start(); send(A_WR);
    check("R2 match", addr_match_o, 1);
    check("R2 dir", dir_rd_o, 0);
    send(8'hFF);
    check("R4 reserved masked", ctrl_o, 8'h77);
    check("R5 aout", aout_en_o, 1);
    check("R5 osc", osc_en_o, 1);
    check("R5 hiz", aout_hiz_o, 0);
    check("R6 mode", in_mode_o, 3);
    check("R6 auto", auto_inc_o, 1);
    check("R7 clamp mode3", chan_o, exp_top(3));
    pulse_stop();
    check("R10 stop clears match", addr_match_o, 0);
    check("R10 ctrl kept", ctrl_o, 8'h77);
  endtask

  task automatic t_clamp();
    logic [7:0] vals [5] = '{8'h13, 8'h23, 8'h03, 8'h32, 8'h11};
    foreach (vals[i]) begin
      int m, s, e;
      write_ctrl(vals[i]);
      m = vals[i][5:4]; s = vals[i][1:0];
      e = (s > exp_top(m)) ? exp_top(m) : s;
      check("R7 clamp", chan_o, e);
      check("R5 aout off", aout_hiz_o, 1);
    end
  endtask

  task automatic t_autoinc();
    write_ctrl(8'h14);          // mode 1, auto, select 0
    conv(); check("R8 step1", chan_o, 1);
    conv(); check("R8 step2", chan_o, 2);
    conv(); check("R8 wrap mode1", chan_o, 0);
    write_ctrl(8'h06);          // mode 0, auto, select 2
    conv(); check("R8 step to 3", chan_o, 3);
    conv(); check("R8 wrap mode0", chan_o, 0);
    write_ctrl(8'h02);          // no auto
    conv(); check("R8 no auto hold", chan_o, 2);
  endtask

  task automatic t_dac();
    pulse_start(); send(A_WR); send(8'h40);
    send(8'h5A);
    check("R9 strobe", dac_vld_o, 1);
    check("R9 data", dac_data_o, 8'h5A);
    check("R9 ctrl kept", ctrl_o, 8'h40);
    @(negedge clk);
    check("R9 strobe single", dac_vld_o, 0);
    pulse_stop();
  endtask

  task automatic t_mismatch();
    pulse_start(); send(8'h92);  // strap 001
    check("R3 strap miss", addr_match_o, 0);
    send(8'h11); send(8'h22);
    check("R3 ignored ctrl", ctrl_o, 8'h40);
    check("R3 ignored dac", dac_vld_o, 0);
    pulse_stop();
    pulse_start(); send(8'h1A);  // fixed part wrong
    check("R3 id miss", addr_match_o, 0);
    send(8'h11);
    check("R3 ignored ctrl2", ctrl_o, 8'h40);
    pulse_start();
    check("R3 start clears", addr_match_o, 0);
    send(A_WR); send(8'h41);
    check("R3 new start works", ctrl_o, 8'h41);
    pulse_stop();
  endtask

  task automatic t_read();
    pulse_start(); send(A_RD);
    check("R11 match", addr_match_o, 1);
    check("R11 dir", dir_rd_o, 1);
    send(8'h33);
    check("R11 ctrl kept", ctrl_o, 8'h41);
    check("R11 no dac", dac_vld_o, 0);
    pulse_stop();
  endtask

  task automatic t_after_stop();
    pulse_start(); send(A_WR); pulse_stop();
    send(8'h22);
    check("R10 byte after stop", ctrl_o, 8'h41);
    check("R10 match low", addr_match_o, 0);
  endtask

  task automatic t_collision();
    write_ctrl(8'h14); conv();   // channel 1, auto on
    pulse_start(); send(A_WR);
    @(negedge clk) begin byte_vld_i = 1; byte_i = 8'h07; conv_done_i = 1; end
    @(negedge clk) begin byte_vld_i = 0; conv_done_i = 0; end
    check("R12 load wins", chan_o, 3);
    pulse_stop();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_write_all_ones();
    t_clamp();
    t_autoinc();
    t_dac();
    t_mismatch();
    t_read();
    t_after_stop();
    t_collision();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule